// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked system and an external asynchronous static RAM that stores 256K words of 16 bits. A client hands it one word access at a time through a valid/ready handshake, with an 18-bit word address, a read/write flag, 16 bits of write data and a two-bit byte enable. The controller then drives the RAM's address, its active-low chip select, output enable and write enable, and its two active-low byte-lane selects. It also owns a tri-state 16-bit data bus. Byte lane 0 is data bits 7:0 and byte lane 1 is bits 15:8.

Every phase of an access lasts a whole number of clock cycles. Each length comes from a nanosecond limit: the count is the ceiling of the time divided by CLK_PERIOD_NS, and never less than one. The counts are N_WP = max(ceil(T_WP_NS), ceil(T_DW_NS)), N_RD = max(ceil(T_AA_NS), ceil(T_OE_NS)), N_HZ = ceil(T_HZ_NS) and N_WC = ceil(T_WC_NS). With the defaults (8 ns clock, 45/25/55/25/20/55 ns), N_WP = 6, N_RD = 7, N_HZ = 3 and N_WC = 7.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every cycle where req_ready is high, the controller holds all five RAM strobes high, keeps its data drivers off and holds rd_valid low.
- R2: A read holds chip select, output enable and the enabled lane selects low, with write enable high, for exactly N_RD cycles. It samples the bus in the last of those cycles. In the cycle that follows, it raises rd_valid for exactly one cycle with the sampled word on rd_data.
- R3: req_be bit 0 enables lane 0 (mem_lb_n, bits 7:0) and bit 1 enables lane 1 (mem_ub_n, bits 15:8). A lane select is low during an access only if its enable bit is set. A write leaves the RAM bytes of disabled lanes unchanged. A read returns zero on rd_data in the bytes of disabled lanes.
- R4: Write enable is low only while chip select is low and output enable is high. It stays low for exactly N_WP consecutive cycles per write, and output enable stays high for the whole write access.
- R5: The controller drives the bus only while output enable is high. It turns its drivers on only after output enable has been high for at least N_HZ cycles. The bus carries the request's write data for the whole time write enable is low. The drivers stay on for the cycle in which write enable rises and are off in the cycle after it.
- R6: req_ready drops in the cycle after a request is accepted. It stays low for max(N_RD+1, N_WC) cycles for a read. For a write whose bus turnaround is already met, it stays low for max(N_WP+3, N_WC) cycles.
- R7: While chip select is low, mem_addr equals the accepted request address and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, returns the controller to idle |
| req_valid | input | 1 | Client presents a request |
| req_ready | output | 1 | Controller is idle and will accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 for bits 7:0, bit 1 for bits 15:8 |
| rd_valid | output | 1 | One-cycle pulse marking valid read data |
| rd_data | output | 16 | Read data, zero in disabled bytes |
| mem_addr | output | AW | RAM word address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | Lane 0 select, active low |
| mem_ub_n | output | 1 | Lane 1 select, active low |
| mem_dq | inout | 16 | Bidirectional RAM data bus |

## Verification
Some rules hold in every cycle, and the embedded properties watch them continuously. These are the strobe relations: write enable only under chip select and never together with output enable, idle strobes whenever ready is high, a write-enable width of exactly N_WP, drivers never on while output enable is low, the release one cycle after write enable rises, a steady address under chip select, and the single-cycle rd_valid pulse. Other behaviour needs a RAM model and a record of what was written, so only the bench's scenarios can show it. That covers the lane masking of stored bytes, the zeroing of disabled read bytes, the exact busy lengths, and the data that crosses the bus. The bench sweeps every lane-enable combination at sixteen addresses, checking both full-word and masked readback after each write.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW            = 18,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WP_NS       = 45,
  parameter int T_DW_NS       = 25,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 25,
  parameter int T_HZ_NS       = 20,
  parameter int T_WC_NS       = 55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  inout  wire  [15:0]   mem_dq
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_WP = (ns2cyc(T_WP_NS) > ns2cyc(T_DW_NS)) ? ns2cyc(T_WP_NS) : ns2cyc(T_DW_NS);
  localparam int N_RD = (ns2cyc(T_AA_NS) > ns2cyc(T_OE_NS)) ? ns2cyc(T_AA_NS) : ns2cyc(T_OE_NS);
  localparam int N_HZ = ns2cyc(T_HZ_NS);
  localparam int N_WC = ns2cyc(T_WC_NS);
  localparam int CW   = $clog2(N_RD + N_WP + N_WC + N_HZ + 8);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WTURN, S_WP, S_WREL, S_HOLD} st_t;

  st_t st, st_n;
  logic [CW-1:0] ph, busy_cnt, oe_hi;
  logic [AW-1:0] addr_q;
  logic [15:0]   wd_q;
  logic [1:0]    be_q;
  logic          cs_q, oe_q, we_q, lane_on, drv_q;

  wire rd_last = (st == S_RD) && (int'(ph) == N_RD - 1);
  wire wp_last = (int'(ph) == N_WP - 1);
  wire turn_ok = (int'(oe_hi) + 1 >= N_HZ);
  wire cyc_ok  = (int'(busy_cnt) + 1 >= N_WC);
  wire [15:0] lane_mask = {{8{be_q[1]}}, {8{be_q[0]}}};

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (req_valid) st_n = req_write ? S_WTURN : S_RD;
      S_RD:    if (rd_last) st_n = S_HOLD;
      S_WTURN: if (turn_ok) st_n = S_WP;
      S_WP:    if (wp_last) st_n = S_WREL;
      S_WREL:  st_n = S_HOLD;
      S_HOLD:  if (cyc_ok) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= '0;
      busy_cnt <= '0;
      oe_hi    <= CW'(N_HZ);
      addr_q   <= '0;
      wd_q     <= '0;
      be_q     <= '0;
      cs_q     <= 1'b1;
      oe_q     <= 1'b1;
      we_q     <= 1'b1;
      lane_on  <= 1'b0;
      drv_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      st       <= st_n;
      ph       <= (st_n != st) ? '0 : ph + 1'b1;
      busy_cnt <= (st == S_IDLE) ? '0 : busy_cnt + 1'b1;
      if (!oe_q)                   oe_hi <= '0;
      else if (int'(oe_hi) < N_HZ) oe_hi <= oe_hi + 1'b1;
      if (st == S_IDLE && req_valid) begin
        addr_q <= req_addr;
        wd_q   <= req_wdata;
        be_q   <= req_be;
      end
      cs_q    <= !(st_n inside {S_RD, S_WTURN, S_WP});
      oe_q    <= (st_n != S_RD);
      we_q    <= (st_n != S_WP);
      lane_on <= st_n inside {S_RD, S_WTURN, S_WP, S_WREL};
      drv_q   <= st_n inside {S_WP, S_WREL};
      rd_valid <= rd_last;
      if (rd_last) rd_data <= mem_dq & lane_mask;
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_cs_n  = cs_q;
  assign mem_oe_n  = oe_q;
  assign mem_we_n  = we_q;
  assign mem_lb_n  = !(lane_on && be_q[0]);
  assign mem_ub_n  = !(lane_on && be_q[1]);
  assign mem_dq    = drv_q ? wd_q : 16'hzzzz;

  logic [CW-1:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_low_cnt <= '0;
    else if (mem_we_n) we_low_cnt <= '0;
    else               we_low_cnt <= we_low_cnt + 1'b1;
  end

  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !drv_q && !rd_valid)); // R1
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R2
  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n)); // R4
  AST_WP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(we_low_cnt) == N_WP)); // R4
  AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> mem_oe_n); // R5
  AST_DRIVE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> (int'(oe_hi) >= N_HZ)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> drv_q); // R5
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !drv_q); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R7

endmodule

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
  localparam int AW = 18;
  localparam int P  = 8;
  localparam int TWP = 45, TDW = 25, TAA = 55, TOE = 25, THZ = 20, TWC = 55;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WP = imax(cdiv(TWP), cdiv(TDW));
  localparam int E_RD = imax(cdiv(TAA), cdiv(TOE));
  localparam int E_WC = cdiv(TWC);
  localparam int E_RBUSY = imax(E_RD + 1, E_WC);
  localparam int E_WBUSY = imax(E_WP + 3, E_WC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  wire [15:0] mem_dq;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.AW(AW), .CLK_PERIOD_NS(P), .T_WP_NS(TWP), .T_DW_NS(TDW),
    .T_AA_NS(TAA), .T_OE_NS(TOE), .T_HZ_NS(THZ), .T_WC_NS(TWC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq(mem_dq));

  logic [15:0] ram [16];
  logic [15:0] shadow [16];
  logic wr_live = 1'b0, lb_s = 1'b1, ub_s = 1'b1;
  logic [3:0] a_s = '0;

  wire ram_drive = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq[7:0]  = (ram_drive && !mem_lb_n) ? ram[mem_addr[3:0]][7:0]  : 8'hzz;
  assign mem_dq[15:8] = (ram_drive && !mem_ub_n) ? ram[mem_addr[3:0]][15:8] : 8'hzz;

  always @(negedge clk) begin
    wr_live <= !mem_cs_n && !mem_we_n;
    lb_s <= mem_lb_n;
    ub_s <= mem_ub_n;
    a_s  <= mem_addr[3:0];
  end

  always @(posedge mem_we_n) begin
    if (wr_live) begin
      if (!lb_s) ram[a_s][7:0]  = mem_dq[7:0];
      if (!ub_s) ram[a_s][15:8] = mem_dq[15:8];
    end
  end

  int total = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic idle_check(input string tag);
    check(req_ready && mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !rd_valid,
          tag, {26'd0, req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 32'h3f);
  endtask

  task automatic op(input bit wr, input logic [AW-1:0] addr, input logic [15:0] wd, input logic [1:0] be);
    int busy = 0, we_low = 0, oe_low = 0, rdv = 0, bad_r4 = 0, bad_r5 = 0, bad_r7 = 0, bad_r3 = 0;
    logic [15:0] got = '0;
    logic [15:0] msk = {{8{be[1]}}, {8{be[0]}}};
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 1000) begin
      busy++;
      if (!mem_we_n) begin
        we_low++;
        if (mem_cs_n || !mem_oe_n) bad_r4++;
        if (mem_dq !== wd) bad_r5++;
      end
      if (wr && !mem_oe_n) bad_r4++;
      if (!mem_oe_n) oe_low++;
      if (!mem_cs_n && mem_addr !== addr) bad_r7++;
      if (!mem_cs_n && ((mem_lb_n !== !be[0]) || (mem_ub_n !== !be[1]))) bad_r3++;
      if (rd_valid) begin rdv++; got = rd_data; end
      @(negedge clk);
    end
    check(busy == (wr ? E_WBUSY : E_RBUSY), "R6 busy length", busy, wr ? E_WBUSY : E_RBUSY);
    check(bad_r7 == 0, "R7 address under chip select", bad_r7, 0);
    check(bad_r3 == 0, "R3 lane selects follow enables", bad_r3, 0);
    if (wr) begin
      check(we_low == E_WP, "R4 write enable width", we_low, E_WP);
      check(bad_r4 == 0, "R4 strobe relations", bad_r4, 0);
      check(bad_r5 == 0, "R5 bus carries write data", bad_r5, 0);
      check(rdv == 0, "R2 no rd_valid on write", rdv, 0);
      shadow[addr[3:0]] = (shadow[addr[3:0]] & ~msk) | (wd & msk);
    end else begin
      check(oe_low == E_RD, "R2 read strobe length", oe_low, E_RD);
      check(rdv == 1, "R2 single rd_valid", rdv, 1);
      check(got === (shadow[addr[3:0]] & msk), "R3 read data lanes", got, shadow[addr[3:0]] & msk);
    end
    idle_check("R1 idle after access");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i] = 16'ha500 + 16'(i * 17);
      shadow[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    idle_check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 idle after reset");
    for (int a = 0; a < 16; a++) begin
      for (int be = 0; be < 4; be++) begin
        logic [AW-1:0] ad = {14'(a * 4099 + be * 7 + 3), 4'(a)};
        logic [15:0] wd = 16'((a * 40503 + be * 9973) ^ 16'h5a3c);
        op(1'b1, ad, wd, 2'(be));
        op(1'b0, {14'(a * 13 + 1), 4'(a)}, 16'h0, 2'b11);
        op(1'b0, {14'(a * 29 + 5), 4'(a)}, 16'h0, 2'(be));
      end
    end
    op(1'b0, 18'h3fff0, 16'h0, 2'b00);
    op(1'b1, 18'h0000f, 16'hffff, 2'b00);
    op(1'b0, 18'h2000f, 16'h0, 2'b11);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule